// File: doc/BRIEF.md
# DS3 Transmit Overhead Source Multiplexer

This block assembles the outbound serial stream of a DS3 C-bit parity M-frame. A position counter walks the frame one bit per clock. At every payload position the bit comes from the payload input. At every overhead position a decoder works out which overhead class the slot belongs to. The bit is then taken from one of three sources: an internal generator, an external overhead port, or a transmit data-link buffer. The class fixes which of these sources are allowed. Static configuration inputs pick the source for each selectable class, and three invert controls corrupt the generated parity, framing and multiframe bits on purpose, for error injection.

The frame has 7 subframes of 8 blocks. Each block is one overhead bit followed by `PAYLOAD_BITS` payload bits (84 in a standard frame). Block 0 of subframes 1 to 7 carries X1, X2, P1, P2, M1, M2 and M3, in that order. Blocks 1, 3, 5 and 7 carry the F bits. Blocks 2, 4 and 6 carry the three C bits of the subframe.

The external overhead port works in one of two modes. In clocked mode the block raises `oh_clk_o` during each overhead slot and takes `ext_d_i` at the end of that cycle. In strobed mode the source drives `ext_en_i` in the cycle before an overhead slot, and the block holds the bit it captured until it is used.

Top module: `ds3_tx_oh_mux`

## Requirements
- R1: The frame is 56 blocks of one overhead bit followed by PAYLOAD_BITS payload bits. Each position appears on `ser_o` one cycle after the counter reaches it, and frames repeat back to back. `sof_o` is 1 only with the first bit of a frame and `oh_o` is 1 only with overhead bits. During payload positions `pay_rd_o` is 1 and `pay_i` is passed through unchanged.
- R2: Block 0 of subframes 1..7 carries X, X, P, P, M, M, M. The uninverted M values are 0, 1, 0.
- R3: Blocks 1, 3, 5 and 7 of every subframe carry F bits with the uninverted values 1, 0, 0, 1.
- R4: P1 and P2 equal the XOR of all payload bits of the previous frame, and are 0 in the first frame after reset. They never come from the external port.
- R5: `cfg_inv_p_i`, `cfg_inv_f_i` and `cfg_inv_m_i` invert the transmitted P, F and M bits respectively.
- R6: The C bits of subframe 3 are CP bits. With `cfg_cp_ext_i`=1 they come from the external port. Otherwise each equals the transmitted P bit.
- R7: The X bits (block 0 of subframes 1 and 2), the FEAC bit (C3 of subframe 1) and the FEBE bits (C bits of subframe 4) each come from the external port when their select is 1. Otherwise they come from `gen_x_i`, `gen_feac_i` and `gen_febe_i`.
- R8: The C bits of subframe 2 are user data-link bits and are always taken from the external port.
- R9: The C bits of subframe 5 are path data-link bits. With `cfg_pmdl_ext_i`=1 they come from the external port. Otherwise they come from `dl_bit_i` if `dl_valid_i`=1, and are 1 if it is 0. `dl_rd_o` is 1 in exactly the buffer-sourced PMDL slots where `dl_valid_i`=1.
- R10: C1 and C2 of subframe 1 and all C bits of subframes 6 and 7 are sent as 1.
- R11: Clocked mode (`cfg_ext_mode_i`=0): `oh_clk_o` is 1 in each cycle in which the counter sits on an overhead slot, and the external bit for that slot is `ext_d_i` in the same cycle.
- R12: Strobed mode (`cfg_ext_mode_i`=1): `oh_clk_o` stays 0. `ext_d_i` is captured at each clock edge where `ext_en_i`=1, and the captured bit, which is 0 after reset, is the external bit for any overhead slot.
- R13: While `rst_n` is 0, `ser_o`, `oh_o` and `sof_o` are 0. After release the frame restarts at its first position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext_mode_i | input | 1 | External port mode: 0 clocked, 1 strobed |
| cfg_x_ext_i | input | 1 | X bits from external port |
| cfg_feac_ext_i | input | 1 | FEAC bit from external port |
| cfg_febe_ext_i | input | 1 | FEBE bits from external port |
| cfg_cp_ext_i | input | 1 | CP bits from external port |
| cfg_pmdl_ext_i | input | 1 | PMDL bits from external port |
| cfg_inv_p_i | input | 1 | Invert transmitted P bits |
| cfg_inv_f_i | input | 1 | Invert transmitted F bits |
| cfg_inv_m_i | input | 1 | Invert transmitted M bits |
| gen_x_i | input | 1 | Internally generated X value |
| gen_feac_i | input | 1 | Internally generated FEAC value |
| gen_febe_i | input | 1 | Internally generated FEBE value |
| pay_i | input | 1 | Payload bit for the current position |
| pay_rd_o | output | 1 | Current position is payload |
| ext_d_i | input | 1 | External overhead data |
| ext_en_i | input | 1 | External overhead strobe (strobed mode) |
| oh_clk_o | output | 1 | External overhead clock (clocked mode) |
| oh_idx_o | output | 6 | Block index of the current position, subframe times 8 plus block |
| dl_bit_i | input | 1 | Data-link buffer bit |
| dl_valid_i | input | 1 | Data-link buffer has a bit |
| dl_rd_o | output | 1 | Data-link buffer bit consumed |
| ser_o | output | 1 | Serial frame output |
| oh_o | output | 1 | `ser_o` carries an overhead bit |
| sof_o | output | 1 | `ser_o` carries the first bit of a frame |

## Verification
The bench builds the block with `PAYLOAD_BITS` set to 4, which makes a frame 280 bits long instead of 4760. That brings two full frames per configuration within reach, so the parity carried from one frame into the next is exercised for every source setting. Both external capture modes, all inversion controls and both data-link buffer states are covered within a few thousand cycles. The class map and slot order do not depend on the payload length, so every overhead position is still visited.

// File: rtl/ds3_oh_pkg.sv
package ds3_oh_pkg;
  localparam int NSUB  = 7;
  localparam int NBLK  = 8;
  localparam int SUB_W = $clog2(NSUB);
  localparam int BLK_W = $clog2(NBLK);
  localparam int IDX_W = SUB_W + BLK_W;

  typedef enum logic [3:0] {
    CL_PAY  = 4'd0,
    CL_X    = 4'd1,
    CL_P    = 4'd2,
    CL_M    = 4'd3,
    CL_F    = 4'd4,
    CL_AIC  = 4'd5,
    CL_NA   = 4'd6,
    CL_FEAC = 4'd7,
    CL_UDL  = 4'd8,
    CL_CP   = 4'd9,
    CL_FEBE = 4'd10,
    CL_PMDL = 4'd11,
    CL_RSV  = 4'd12
  } oh_cls_e;
endpackage

// File: rtl/ds3_frame_cnt.sv
module ds3_frame_cnt
  import ds3_oh_pkg::*;
#(
  parameter int PAYLOAD_BITS = 84
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [BLK_W-1:0] blk_idx,
  output logic [SUB_W-1:0] sub_idx,
  output logic             at_oh,
  output logic             at_sof,
  output logic             at_eof
);
  localparam int BW = $clog2(PAYLOAD_BITS + 1);

  logic [BW-1:0]    bit_q, bit_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic bit_last, blk_last, sub_last;

  always_comb begin
    bit_last = (bit_q == BW'(PAYLOAD_BITS));
    blk_last = (blk_q == BLK_W'(NBLK - 1));
    sub_last = (sub_q == SUB_W'(NSUB - 1));
    bit_d = bit_last ? '0 : bit_q + 1'b1;
    blk_d = blk_q;
    sub_d = sub_q;
    if (bit_last) begin
      blk_d = blk_last ? '0 : blk_q + 1'b1;
      if (blk_last) begin
        sub_d = sub_last ? '0 : sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      blk_q <= '0;
      sub_q <= '0;
    end else begin
      bit_q <= bit_d;
      blk_q <= blk_d;
      sub_q <= sub_d;
    end
  end

  assign blk_idx = blk_q;
  assign sub_idx = sub_q;
  assign at_oh   = (bit_q == '0);
  assign at_sof  = at_oh && (blk_q == '0) && (sub_q == '0);
  assign at_eof  = bit_last && blk_last && sub_last;
endmodule

// File: rtl/ds3_slot_decode.sv
module ds3_slot_decode
  import ds3_oh_pkg::*;
(
  input  logic             at_oh,
  input  logic [BLK_W-1:0] blk_idx,
  input  logic [SUB_W-1:0] sub_idx,
  output oh_cls_e          cls,
  output logic             pattern
);
  logic [1:0] c_sel;

  always_comb begin
    cls     = CL_PAY;
    pattern = 1'b0;
    c_sel   = 2'(blk_idx >> 1) - 2'd1;
    if (at_oh) begin
      if (blk_idx == '0) begin
        unique case (sub_idx)
          SUB_W'(0), SUB_W'(1): cls = CL_X;
          SUB_W'(2), SUB_W'(3): cls = CL_P;
          default: begin
            cls     = CL_M;
            pattern = (sub_idx == SUB_W'(5));
          end
        endcase
      end else if (blk_idx[0]) begin
        cls     = CL_F;
        pattern = (blk_idx == BLK_W'(1)) || (blk_idx == BLK_W'(7));
      end else begin
        unique case (sub_idx)
          SUB_W'(0): begin
            if (c_sel == 2'd0)      cls = CL_AIC;
            else if (c_sel == 2'd1) cls = CL_NA;
            else                    cls = CL_FEAC;
          end
          SUB_W'(1): cls = CL_UDL;
          SUB_W'(2): cls = CL_CP;
          SUB_W'(3): cls = CL_FEBE;
          SUB_W'(4): cls = CL_PMDL;
          default:   cls = CL_RSV;
        endcase
      end
    end
  end
endmodule

// File: rtl/ds3_parity_acc.sv
module ds3_parity_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic pay_en,
  input  logic pay_bit,
  input  logic at_eof,
  output logic par_prev
);
  logic acc_q, acc_d, prev_q, prev_d, acc_nx;

  always_comb begin
    acc_nx = acc_q ^ (pay_en & pay_bit);
    acc_d  = at_eof ? 1'b0 : acc_nx;
    prev_d = at_eof ? acc_nx : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      prev_q <= prev_d;
    end
  end

  assign par_prev = prev_q;
endmodule

// File: rtl/ds3_ext_capture.sv
module ds3_ext_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic strobed,
  input  logic at_oh,
  input  logic ext_d,
  input  logic ext_en,
  output logic oh_clk,
  output logic ext_bit
);
  logic hold_q, hold_d, hold_ce;

  always_comb begin
    hold_ce = strobed && ext_en;
    hold_d  = hold_ce ? ext_d : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign oh_clk  = !strobed && at_oh;
  assign ext_bit = strobed ? hold_q : ext_d;
endmodule

// File: rtl/ds3_tx_oh_mux.sv
module ds3_tx_oh_mux
  import ds3_oh_pkg::*;
#(
  parameter int PAYLOAD_BITS = 84
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_ext_mode_i,
  input  logic             cfg_x_ext_i,
  input  logic             cfg_feac_ext_i,
  input  logic             cfg_febe_ext_i,
  input  logic             cfg_cp_ext_i,
  input  logic             cfg_pmdl_ext_i,
  input  logic             cfg_inv_p_i,
  input  logic             cfg_inv_f_i,
  input  logic             cfg_inv_m_i,
  input  logic             gen_x_i,
  input  logic             gen_feac_i,
  input  logic             gen_febe_i,
  input  logic             pay_i,
  output logic             pay_rd_o,
  input  logic             ext_d_i,
  input  logic             ext_en_i,
  output logic             oh_clk_o,
  output logic [IDX_W-1:0] oh_idx_o,
  input  logic             dl_bit_i,
  input  logic             dl_valid_i,
  output logic             dl_rd_o,
  output logic             ser_o,
  output logic             oh_o,
  output logic             sof_o
);
  logic [BLK_W-1:0] blk_idx;
  logic [SUB_W-1:0] sub_idx;
  logic at_oh, at_sof, at_eof;
  oh_cls_e slot_cls;
  logic pattern, par_prev, ext_bit, p_tx, dl_src;
  logic bit_nx, ser_q, oh_q, sof_q;

  ds3_frame_cnt #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .blk_idx(blk_idx), .sub_idx(sub_idx),
    .at_oh(at_oh), .at_sof(at_sof), .at_eof(at_eof)
  );

  ds3_slot_decode u_dec (
    .at_oh(at_oh), .blk_idx(blk_idx), .sub_idx(sub_idx),
    .cls(slot_cls), .pattern(pattern)
  );

  ds3_parity_acc u_par (
    .clk(clk), .rst_n(rst_n), .pay_en(!at_oh), .pay_bit(pay_i),
    .at_eof(at_eof), .par_prev(par_prev)
  );

  ds3_ext_capture u_ext (
    .clk(clk), .rst_n(rst_n), .strobed(cfg_ext_mode_i), .at_oh(at_oh),
    .ext_d(ext_d_i), .ext_en(ext_en_i), .oh_clk(oh_clk_o), .ext_bit(ext_bit)
  );

  always_comb begin
    p_tx   = par_prev ^ cfg_inv_p_i;
    dl_src = dl_valid_i ? dl_bit_i : 1'b1;
    unique case (slot_cls)
      CL_PAY:  bit_nx = pay_i;
      CL_X:    bit_nx = cfg_x_ext_i ? ext_bit : gen_x_i;
      CL_P:    bit_nx = p_tx;
      CL_M:    bit_nx = pattern ^ cfg_inv_m_i;
      CL_F:    bit_nx = pattern ^ cfg_inv_f_i;
      CL_FEAC: bit_nx = cfg_feac_ext_i ? ext_bit : gen_feac_i;
      CL_UDL:  bit_nx = ext_bit;
      CL_CP:   bit_nx = cfg_cp_ext_i ? ext_bit : p_tx;
      CL_FEBE: bit_nx = cfg_febe_ext_i ? ext_bit : gen_febe_i;
      CL_PMDL: bit_nx = cfg_pmdl_ext_i ? ext_bit : dl_src;
      default: bit_nx = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_q <= 1'b0;
      oh_q  <= 1'b0;
      sof_q <= 1'b0;
    end else begin
      ser_q <= bit_nx;
      oh_q  <= at_oh;
      sof_q <= at_sof;
    end
  end

  assign pay_rd_o = !at_oh;
  assign dl_rd_o  = (slot_cls == CL_PMDL) && !cfg_pmdl_ext_i && dl_valid_i;
  assign oh_idx_o = {sub_idx, blk_idx};
  assign ser_o    = ser_q;
  assign oh_o     = oh_q;
  assign sof_o    = sof_q;
endmodule

// File: rtl/ds3_tx_oh_chk.sv
module ds3_tx_oh_chk
  import ds3_oh_pkg::*;
#(
  parameter int PAYLOAD_BITS = 84
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_ext_mode_i,
  input logic       ext_d_i,
  input logic       oh_clk_o,
  input logic       pay_rd_o,
  input logic       dl_rd_o,
  input logic       ser_o,
  input logic       oh_o,
  input logic       sof_o,
  input logic [3:0] cls,
  input logic       p_tx
);
  localparam int FRAME_LEN = NSUB * NBLK * (PAYLOAD_BITS + 1);

  int   gap_q;
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= sof_o ? 0 : gap_q + 1;
      seen_q <= seen_q | sof_o;
    end
  end

  a_r1_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_o && seen_q) |-> (gap_q == FRAME_LEN - 1));

  a_r1_sof_due: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && gap_q == FRAME_LEN - 1) |-> sof_o);

  a_r1_payload_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pay_rd_o |=> !oh_o);

  a_r4_p_internal: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CL_P) |=> (ser_o == $past(p_tx)));

  a_r8_udl_external: assert property (@(posedge clk) disable iff (!rst_n)
    (cls == CL_UDL && !cfg_ext_mode_i) |=> (ser_o == $past(ext_d_i)));

  a_r9_dl_rd_slot: assert property (@(posedge clk) disable iff (!rst_n)
    dl_rd_o |-> (cls == CL_PMDL));

  a_r12_no_oh_clk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ext_mode_i |-> !oh_clk_o);
endmodule

bind ds3_tx_oh_mux ds3_tx_oh_chk #(.PAYLOAD_BITS(PAYLOAD_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ext_mode_i(cfg_ext_mode_i),
  .ext_d_i(ext_d_i), .oh_clk_o(oh_clk_o), .pay_rd_o(pay_rd_o),
  .dl_rd_o(dl_rd_o), .ser_o(ser_o), .oh_o(oh_o), .sof_o(sof_o),
  .cls(slot_cls), .p_tx(p_tx)
);

// File: tb/tb_ds3_tx_oh_mux.sv
`timescale 1ns/1ps
module tb_ds3_tx_oh_mux;
  localparam int PB    = 4;
  localparam int SLOT  = PB + 1;
  localparam int FRAME = 56 * SLOT;
  localparam int NVEC  = 6;
  // vector bits, msb first: mode, x_ext, feac_ext, febe_ext, cp_ext, pmdl_ext,
  // inv_p, inv_f, inv_m, gen_x, gen_feac, gen_febe, dl_valid
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0_00000_000_000_0,
    13'b0_11111_000_101_1,
    13'b1_11111_111_010_0,
    13'b1_00000_010_111_1,
    13'b0_10101_101_011_1,
    13'b1_01010_110_100_0
  };

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_ext_mode_i, cfg_x_ext_i, cfg_feac_ext_i, cfg_febe_ext_i;
  logic cfg_cp_ext_i, cfg_pmdl_ext_i, cfg_inv_p_i, cfg_inv_f_i, cfg_inv_m_i;
  logic gen_x_i, gen_feac_i, gen_febe_i, pay_i, pay_rd_o;
  logic ext_d_i, ext_en_i, oh_clk_o, dl_bit_i, dl_valid_i, dl_rd_o;
  logic [5:0] oh_idx_o;
  logic ser_o, oh_o, sof_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  ds3_tx_oh_mux #(.PAYLOAD_BITS(PB)) dut (.*);

  // class codes: 0 pay 1 X 2 P 3 M 4 F 5 fixed-one 6 FEAC 7 UDL 8 CP 9 FEBE 10 PMDL
  function automatic int cls_of(int k);
    int b = (k / SLOT) % 8;
    int s = (k / SLOT) / 8;
    if (k % SLOT != 0) return 0;
    if (b == 0) return (s < 2) ? 1 : (s < 4) ? 2 : 3;
    if (b % 2 == 1) return 4;
    case (s)
      0: return (b == 6) ? 6 : 5;
      1: return 7;
      2: return 8;
      3: return 9;
      4: return 10;
      default: return 5;
    endcase
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at time %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_vec(logic [12:0] v);
    logic hold, acc, prev, e_ser, e_oh, e_sof, ext, pt;
    bit have;
    int k, c;
    {cfg_ext_mode_i, cfg_x_ext_i, cfg_feac_ext_i, cfg_febe_ext_i, cfg_cp_ext_i,
     cfg_pmdl_ext_i, cfg_inv_p_i, cfg_inv_f_i, cfg_inv_m_i, gen_x_i, gen_feac_i,
     gen_febe_i, dl_valid_i} = v;
    rst_n = 1'b0;
    ext_en_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R13 reset ser", ser_o, 1'b0);
    check("R13 reset oh", oh_o, 1'b0);
    check("R13 reset sof", sof_o, 1'b0);
    rst_n = 1'b1;
    hold = 0; acc = 0; prev = 0; have = 0; k = 0;
    e_ser = 0; e_oh = 0; e_sof = 0;
    for (int t = 0; t <= 2 * FRAME; t++) begin
      if (have) begin
        check("R1 sof", sof_o, e_sof);
        check("R1 oh flag", oh_o, e_oh);
        check("R1-R12 serial bit", ser_o, e_ser);
      end
      if (t == 2 * FRAME) break;
      c = cls_of(k);
      pay_i    = 1'($urandom_range(0, 1));
      ext_d_i  = 1'($urandom_range(0, 1));
      dl_bit_i = 1'($urandom_range(0, 1));
      ext_en_i = cfg_ext_mode_i && (cls_of((k + 1) % FRAME) != 0);
      #1;
      check("R11 oh_clk", oh_clk_o, !cfg_ext_mode_i && (c != 0));
      check("R1 pay_rd", pay_rd_o, c == 0);
      check("R9 dl_rd", dl_rd_o, (c == 10) && !cfg_pmdl_ext_i && dl_valid_i);
      ext = cfg_ext_mode_i ? hold : ext_d_i;
      pt  = prev ^ cfg_inv_p_i;
      case (c)
        0:  e_ser = pay_i;
        1:  e_ser = cfg_x_ext_i ? ext : gen_x_i;
        2:  e_ser = pt;                                         // R4
        3:  e_ser = ((k / SLOT) / 8 == 5) ^ cfg_inv_m_i;        // R2 R5
        4:  e_ser = ((k / SLOT) % 8 == 1 || (k / SLOT) % 8 == 7) ^ cfg_inv_f_i; // R3
        5:  e_ser = 1'b1;                                       // R10
        6:  e_ser = cfg_feac_ext_i ? ext : gen_feac_i;          // R7
        7:  e_ser = ext;                                        // R8
        8:  e_ser = cfg_cp_ext_i ? ext : pt;                    // R6
        9:  e_ser = cfg_febe_ext_i ? ext : gen_febe_i;          // R7
        default: e_ser = cfg_pmdl_ext_i ? ext : (dl_valid_i ? dl_bit_i : 1'b1); // R9
      endcase
      e_oh  = (c != 0);
      e_sof = (k == 0);
      have  = 1;
      if (ext_en_i) hold = ext_d_i;                              // R12
      if (c == 0) acc = acc ^ pay_i;
      if (k == FRAME - 1) begin prev = acc; acc = 0; end
      k = (k + 1) % FRAME;
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    {cfg_ext_mode_i, cfg_x_ext_i, cfg_feac_ext_i, cfg_febe_ext_i, cfg_cp_ext_i,
     cfg_pmdl_ext_i, cfg_inv_p_i, cfg_inv_f_i, cfg_inv_m_i, gen_x_i, gen_feac_i,
     gen_febe_i, dl_valid_i} = '0;
    pay_i = 0; ext_d_i = 0; ext_en_i = 0; dl_bit_i = 0;
    for (int i = 0; i < NVEC; i++) run_vec(VEC[i]);

    // directed: reset in mid-frame restarts at the first position (R13)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (37) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R13 async reset ser", ser_o, 1'b0);
    check("R13 async reset oh", oh_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 restart sof", sof_o, 1'b1);
    check("R13 restart oh", oh_o, 1'b1);
    check("R13 restart idx", oh_idx_o == 6'd0, 1'b1);
    repeat (SLOT) @(negedge clk);
    check("R1 second block idx", oh_idx_o == 6'd1, 1'b1);
    check("R1 second block sof", sof_o, 1'b0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule